// File: doc/BRIEF.md
# IrDA SIR Transmit Pulse Encoder

This block sits between a UART transmit line and an infrared emitter driver. It takes the idle-high NRZ stream of 8-bit, no-parity, one-stop-bit frames and turns every zero bit into a single short active-high pulse. One bits, the stop bit and the idle line produce no light. Bit timing comes from a 16x bit-rate enable (`tick16`) that a shared baud generator supplies. The block runs from the 3.6864 MHz reference clock, so the fixed short pulse of 1.627 µs is exactly six clock cycles at every bit rate.

A mode input selects between this fixed short pulse and a pulse that lasts 3/16 of the current bit time, which is three `tick16` periods. A data-mode enable gates the whole path. While it is low the infrared output stays quiet and any frame in progress is dropped. The rate and mode values come from a separate programming block. An active-low indicator output is asserted for as long as a frame is being encoded.

The controller is a four-state machine. In `ST_IDLE` it waits for a falling edge on the line and emits the start pulse. `ST_START` confirms the start bit at mid-bit. It returns to `ST_IDLE` on a glitch and otherwise moves to `ST_DATA` at the end of the bit. `ST_DATA` samples each data bit, least significant first, at the start of its bit period. After the eighth bit it moves to `ST_STOP`. `ST_STOP` returns to `ST_IDLE` at the middle of the stop bit. From every state, a low data-mode enable forces `ST_IDLE`.

Top module: `sir_tx_encoder`

## Requirements
- R1: During reset and after it, before any frame arrives, `ir_out` is 0 and `tx_led_n` is 1.
- R2: With `data_en` high, a falling edge on `txd_in` while idle raises `ir_out` on the second rising clock edge after the edge is captured. This start-bit pulse always appears.
- R3: Data bits follow the start bit, least significant first. Bit j (0..7) is sampled at the 16·(j+1)-th `tick16` after start detection. `ir_out` rises on that clock edge when the bit is 0, and does not rise when it is 1. The stop bit never pulses, so a frame yields 1 + (number of zero data bits) pulses.
- R4: With `wide_sel` = 0, every pulse lasts exactly SHORT_CLKS (6) clock cycles, independent of the bit rate.
- R5: With `wide_sel` = 1, a pulse ends on the third `tick16` after it began. A data-bit pulse therefore spans three tick periods. The start pulse ends on the third tick after detection.
- R6: If `txd_in` is back high at the 8th tick after start detection, the frame is abandoned. The machine returns to idle at that edge, emits no data-bit pulse, and accepts the next falling edge.
- R7: The machine returns to idle on the 8th tick after entering the stop bit. `tx_led_n` rises on that edge and is low on the cycle before.
- R8: While `data_en` is 0, `ir_out` is 0 and `tx_led_n` is 1 from the next clock edge on. Line activity produces no pulse, and a pulse in progress is cut off.
- R9: `tx_led_n` is 0 exactly while a frame is in progress (any state but idle). `ir_out` is never high while `tx_led_n` is 1.
- R10: A line that is already low when `data_en` goes high does not start a frame. Only a high-to-low transition does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (3.6864 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| data_en | input | 1 | High selects data mode; low silences the encoder |
| wide_sel | input | 1 | 0: fixed six-clock pulse; 1: 3/16-bit-time pulse |
| txd_in | input | 1 | NRZ UART transmit line, idle high |
| ir_out | output | 1 | Active-high drive to the infrared emitter |
| tx_led_n | output | 1 | Active-low transmit activity indicator |

## Verification
The bench sweeps all 256 byte values in short mode and a set of bytes in wide mode at two tick rates. For each frame it checks every pulse's start cycle and width. An encoder that took bits in the wrong order, sampled one bit late or pulsed on the stop bit would place pulses at the wrong offsets or produce the wrong count. A width counter that ran in the wrong unit would get the width wrong in one of the two modes. A short low glitch, followed by a real frame, shows whether the start bit is confirmed at mid-bit; a missed rejection would swallow the next start edge. Dropping `data_en` during a pulse and raising it over a line that is already low would expose an encoder that keeps driving the emitter, or one that takes a level for an edge.

// File: rtl/sir_tx_pkg.sv
package sir_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } enc_state_t;

endpackage

// File: rtl/sir_line_sync.sv
module sir_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_q,
    output logic fall
);

    logic line_qq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= 1'b1;
            line_qq <= 1'b1;
        end else begin
            line_q  <= line_in;
            line_qq <= line_q;
        end
    end

    assign fall = line_qq & ~line_q;

endmodule

// File: rtl/sir_bit_timer.sv
module sir_bit_timer #(
    parameter int OVERSAMPLE = 16,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic             mid,
    output logic             wrap,
    output logic [IDX_W-1:0] bit_idx
);

    localparam int PH_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVERSAMPLE / 2 - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

    logic [PH_W-1:0] phase;

    assign mid  = tick && !clr && (phase == PH_MID);
    assign wrap = tick && !clr && (phase == PH_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase   <= '0;
            bit_idx <= '0;
        end else if (tick) begin
            phase <= wrap ? '0 : phase + 1'b1;
            if (wrap) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sir_pulse_shaper.sv
module sir_pulse_shaper #(
    parameter int SHORT_CLKS = 6,
    parameter int WIDE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic fire,
    input  logic tick,
    input  logic wide,
    output logic pulse
);

    localparam int CNT_MAX = (SHORT_CLKS > WIDE_TICKS) ? SHORT_CLKS : WIDE_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_CLKS - 1);
    localparam logic [CNT_W-1:0] WIDE_END  = CNT_W'(WIDE_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pulse <= 1'b0;
            cnt   <= '0;
        end else if (fire) begin
            pulse <= 1'b1;
            cnt   <= '0;
        end else if (pulse) begin
            if (wide) begin
                if (tick) begin
                    if (cnt >= WIDE_END) pulse <= 1'b0;
                    else                 cnt   <= cnt + 1'b1;
                end
            end else begin
                if (cnt >= SHORT_END) pulse <= 1'b0;
                else                  cnt   <= cnt + 1'b1;
            end
        end
    end

    // A request from the controller always produces a pulse on the next edge.
    assert_fire_starts_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clear) |=> pulse);

    // In short mode the width counter never passes its six-clock limit.
    assert_short_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !wide) |-> (cnt < CNT_W'(SHORT_CLKS)));

endmodule

// File: rtl/sir_tx_encoder.sv
module sir_tx_encoder #(
    parameter int OVERSAMPLE = 16,
    parameter int SHORT_CLKS = 6,
    parameter int WIDE_TICKS = 3,
    parameter int DATA_BITS  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic data_en,
    input  logic wide_sel,
    input  logic txd_in,
    output logic ir_out,
    output logic tx_led_n
);

    import sir_tx_pkg::*;

    localparam int IDX_W = $clog2(DATA_BITS + 2);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS);

    enc_state_t       state_q, state_d;
    logic             line_q, fall;
    logic             t_mid, t_wrap;
    logic [IDX_W-1:0] bit_idx;
    logic             start_hit, fire;

    sir_line_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(txd_in),
        .line_q (line_q),
        .fall   (fall)
    );

    sir_bit_timer #(
        .OVERSAMPLE(OVERSAMPLE),
        .IDX_W     (IDX_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_hit),
        .tick   (tick16),
        .mid    (t_mid),
        .wrap   (t_wrap),
        .bit_idx(bit_idx)
    );

    sir_pulse_shaper #(
        .SHORT_CLKS(SHORT_CLKS),
        .WIDE_TICKS(WIDE_TICKS)
    ) u_shaper (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(!data_en),
        .fire (fire),
        .tick (tick16),
        .wide (wide_sel),
        .pulse(ir_out)
    );

    assign start_hit = data_en && (state_q == ST_IDLE) && fall;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and pulse request
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) begin
                    state_d = ST_START;
                    fire    = 1'b1;
                end
            end
            ST_START: begin
                if (t_mid && line_q) begin
                    state_d = ST_IDLE;
                end else if (t_wrap) begin
                    state_d = ST_DATA;
                    fire    = !line_q;
                end
            end
            ST_DATA: begin
                if (t_wrap) begin
                    if (bit_idx == LAST_IDX) state_d = ST_STOP;
                    else                     fire    = !line_q;
                end
            end
            ST_STOP: begin
                if (t_mid) state_d = ST_IDLE;
            end
        endcase
        if (!data_en) begin
            state_d = ST_IDLE;
            fire    = 1'b0;
        end
    end

    // Outputs
    always_comb begin
        tx_led_n = (state_q == ST_IDLE);
    end

    assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !data_en |=> (!ir_out && tx_led_n));

    assert_pulse_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ir_out |-> !tx_led_n);

    assert_pulse_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_out) |-> $past(start_hit || t_wrap));

    assert_stop_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && t_mid) |=> tx_led_n);

endmodule

// File: tb/test_sir_tx_encoder.sv
`timescale 1ns/1ps
module test_sir_tx_encoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic data_en = 1'b1;
    logic wide_sel = 1'b0;
    logic txd_in = 1'b1;
    logic ir_out, tx_led_n;

    int errors = 0;
    int checks = 0;
    int tp = 3;
    int tcnt = 0;
    int cyc = 0;
    int t0 = 0;
    logic mon_on = 1'b0;
    logic ir_prev = 1'b0;
    int npulse = 0;
    int wcur = 0;
    int rise_at[16];
    int width_at[16];

    always #2.5 clk = ~clk;

    sir_tx_encoder i_sir_tx_encoder (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick16  (tick16),
        .data_en (data_en),
        .wide_sel(wide_sel),
        .txd_in  (txd_in),
        .ir_out  (ir_out),
        .tx_led_n(tx_led_n)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tcnt >= tp - 1) begin
            tcnt   = 0;
            tick16 = 1'b1;
        end else begin
            tcnt   = tcnt + 1;
            tick16 = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if (ir_out && !ir_prev) begin
                if (npulse < 16) rise_at[npulse] = cyc - t0;
                wcur   = 0;
                npulse = npulse + 1;
            end
            if (ir_out) wcur = wcur + 1;
            if (!ir_out && ir_prev && npulse > 0 && npulse <= 16) width_at[npulse-1] = wcur;
        end
        ir_prev = ir_out;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic wait_rel(input int n);
        while (cyc - t0 < n) @(negedge clk);
    endtask

    task automatic align_start();
        do @(posedge clk); while (tick16 !== 1'b1);
        @(negedge clk);
        t0     = cyc;
        npulse = 0;
        mon_on = 1'b1;
    endtask

    task automatic check_pulses(input logic [7:0] b, input bit on);
        int exp_n;
        int er[16];
        int ew[16];
        int ws, wd;
        ws = wide_sel ? 3 * tp - 2 : 6;
        wd = wide_sel ? 3 * tp : 6;
        exp_n = 0;
        if (on) begin
            er[0] = 2; ew[0] = ws; exp_n = 1;
            for (int j = 0; j < 8; j++) begin
                if (!b[j]) begin
                    er[exp_n] = 16 * tp * (j + 1);
                    ew[exp_n] = wd;
                    exp_n = exp_n + 1;
                end
            end
        end
        chk(npulse == exp_n, on ? "R3 pulse count" : "R8 pulse count", npulse, exp_n);
        if (npulse == exp_n) begin
            for (int k = 0; k < exp_n; k++) begin
                chk(rise_at[k] == er[k], (k == 0) ? "R2 start pulse cycle" : "R3 data pulse cycle",
                    rise_at[k], er[k]);
                chk(width_at[k] == ew[k], wide_sel ? "R5 wide width" : "R4 short width",
                    width_at[k], ew[k]);
            end
        end
    endtask

    task automatic send_frame(input logic [7:0] b);
        bit on;
        on = data_en;
        align_start();
        txd_in = 1'b0;
        wait_rel(5);
        chk(tx_led_n == !on, on ? "R9 led busy" : "R8 led quiet", tx_led_n, !on);
        for (int j = 0; j < 8; j++) begin
            wait_rel(16 * tp * (j + 1) - 3);
            txd_in = b[j];
        end
        wait_rel(16 * tp * 9 - 3);
        txd_in = 1'b1;
        if (on) begin
            wait_rel(16 * tp * 9 + 8 * tp - 1);
            chk(tx_led_n == 1'b0, "R7 still in stop", tx_led_n, 0);
            wait_rel(16 * tp * 9 + 8 * tp);
            chk(tx_led_n == 1'b1, "R7 idle after stop", tx_led_n, 1);
        end
        wait_rel(16 * tp * 10 + 4);
        mon_on = 1'b0;
        check_pulses(b, on);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        chk(1'b0, "R9 watchdog timeout", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(ir_out == 1'b0, "R1 ir in reset", ir_out, 0);
        chk(tx_led_n == 1'b1, "R1 led in reset", tx_led_n, 1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(ir_out == 1'b0, "R1 ir after reset", ir_out, 0);
        chk(tx_led_n == 1'b1, "R1 led after reset", tx_led_n, 1);

        // Short mode, every byte value
        tp = 3; wide_sel = 1'b0;
        for (int v = 0; v < 256; v++) send_frame(8'(v));

        // Wide mode at two tick rates
        wide_sel = 1'b1;
        for (int v = 0; v < 8; v++) send_frame(8'(v * 37 + 5));
        tp = 5;
        for (int v = 0; v < 8; v++) send_frame(8'(v * 29 + 2));
        send_frame(8'h00);
        send_frame(8'hFF);

        // R6: glitch rejected, next frame still decoded
        tp = 3; wide_sel = 1'b0;
        align_start();
        txd_in = 1'b0;
        wait_rel(2 * tp);
        txd_in = 1'b1;
        wait_rel(8 * tp + 3);
        chk(tx_led_n == 1'b1, "R6 idle after glitch", tx_led_n, 1);
        wait_rel(9 * tp);
        mon_on = 1'b0;
        chk(npulse == 1, "R6 only start pulse", npulse, 1);
        send_frame(8'h5A);

        // R8: pulse cut off when data mode drops
        tp = 5; wide_sel = 1'b1;
        align_start();
        txd_in = 1'b0;
        wait_rel(4);
        chk(ir_out == 1'b1, "R5 wide start pulse active", ir_out, 1);
        data_en = 1'b0;
        @(negedge clk);
        chk(ir_out == 1'b0, "R8 pulse cut", ir_out, 0);
        chk(tx_led_n == 1'b1, "R8 led off", tx_led_n, 1);
        mon_on = 1'b0;
        txd_in = 1'b1;
        repeat (10) @(negedge clk);

        // R8: line activity ignored while off
        send_frame(8'h00);

        // R10: line already low when data mode turns on
        txd_in = 1'b0;
        repeat (10) @(negedge clk);
        t0 = cyc; npulse = 0; mon_on = 1'b1;
        data_en = 1'b1;
        repeat (60) @(negedge clk);
        mon_on = 1'b0;
        chk(npulse == 0, "R10 no pulse from level", npulse, 0);
        chk(tx_led_n == 1'b1, "R10 stays idle", tx_led_n, 1);
        txd_in = 1'b1;
        repeat (10) @(negedge clk);
        wide_sel = 1'b0;
        send_frame(8'h3C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule